// File: doc/BRIEF.md
# Arm Cell Capacitor Balancing Selector

This block picks the output level of every cell in one converter arm on each control update. The arm mixes full-bridge cells, which can give +V, 0 or −V, with half-bridge cells, which can give +V or 0. A controller supplies the measured capacitor voltages, the sign of the arm current, a flag naming the current half-cycle and two requested counts (cells to insert at +V and at −V). The block ranks the cells by capacitor voltage and turns that ranking into switch gate bits, so that charging current goes to the emptiest cells and discharging current to the fullest.

In the half-cycle that uses negative levels, only the full-bridge cells take part and all half-bridge cells stay bypassed. The −V cells come from one end of the ranking and the +V cells from the other end, so that both groups move toward the mean. In the other half-cycle every cell is ranked and only +V is issued. An over-current trip input forces every switch open until reset.

Top module: `cell_balance_selector`

## Requirements
- R1: After reset every gate nibble is 0000 (all switches open) and `done` is low.
- R2: Cell i drives `gates[4i+3:4i]`. Cells 0..N_FULL−1 are full-bridge cells, with bits {S1,S2,S3,S4} set to 1001 for +V, 0110 for −V, 0101 or 1010 for zero, and 0000 for open. The remaining cells are half-bridge cells, with bits {S1,S2,0,0} set to 1000 for +V and 0100 for bypass.
- R3: An `upd` sampled high at a clock edge updates `gates` at that same edge and raises `done` for the following cycle. Without `upd`, `gates` holds and `done` is low.
- R4: With `neg_half`=1 and `i_pos`=1, the highest-voltage full-bridge cells are set to −V and the lowest-voltage full-bridge cells are set to +V.
- R5: With `neg_half`=1 and `i_pos`=0, the choice is mirrored: the lowest-voltage full-bridge cells get −V and the highest get +V.
- R6: With `neg_half`=1, every half-bridge cell is bypassed (0100).
- R7: With `neg_half`=0, no cell gets −V. All cells are ranked, and the lowest-voltage cells (`i_pos`=1) or the highest-voltage cells (`i_pos`=0) are inserted at +V.
- R8: The negative count is clamped to MAX_NEG and applies only while `neg_half`=1. The positive count is clamped to N_FULL minus the clamped negative count while `neg_half`=1, and to N_CELLS otherwise.
- R9: Cells with equal voltages are ordered by lower index first, in both ascending and descending rankings.
- R10: A full-bridge cell at zero output uses 0101 on the first update after reset. The pattern then alternates between 1010 and 0101 on each later accepted update.
- R11: `trip` high forces all gates to 0000 at the next edge and keeps them there, with no `done`, ignoring `upd`, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd | input | 1 | Update strobe |
| vcap | input | N_CELLS*VW | Capacitor voltages, cell i at [i*VW +: VW] |
| i_pos | input | 1 | Arm current is positive |
| neg_half | input | 1 | Half-cycle that uses negative levels |
| n_pos_req | input | CW | Requested +V insertions |
| n_neg_req | input | CW | Requested −V insertions |
| trip | input | 1 | Over-current block |
| gates | output | 4*N_CELLS | Gate bits per cell |
| done | output | 1 | One-cycle update completion pulse |

## Verification
The bench builds the block with three cells, two of them full-bridge, and a negative limit of one. These values make every level appear in one update and let the requested counts of 0..3 exceed both clamps. Narrow random voltages (0..7) produce frequent ties that exercise the index ordering, while wide ones cover the full comparator range. Directed cases cover equal voltages, the trip latch and the restart of the bypass alternation after reset.

// File: rtl/cell_balance_selector.sv
module cell_balance_selector #(
  parameter int N_CELLS = 3,
  parameter int N_FULL  = 2,
  parameter int MAX_NEG = 1,
  parameter int VW      = 12,
  localparam int CW     = $clog2(N_CELLS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd,
  input  logic [N_CELLS*VW-1:0] vcap,
  input  logic                  i_pos,
  input  logic                  neg_half,
  input  logic [CW-1:0]         n_pos_req,
  input  logic [CW-1:0]         n_neg_req,
  input  logic                  trip,
  output logic [4*N_CELLS-1:0]  gates,
  output logic                  done
);
  localparam logic [3:0] FB_POS = 4'b1001, FB_NEG = 4'b0110;
  localparam logic [3:0] FB_ZA = 4'b0101, FB_ZB = 4'b1010;
  localparam logic [3:0] HB_POS = 4'b1000, HB_BYP = 4'b0100;

  logic tripped, alt;
  logic [4*N_CELLS-1:0] gnext;
  int rank_lo [N_CELLS];
  int rank_hi [N_CELLS];
  int nneg, npos, cap;

  always_comb begin
    nneg = 0;
    if (neg_half) nneg = (int'(n_neg_req) > MAX_NEG) ? MAX_NEG : int'(n_neg_req);
    cap  = neg_half ? (N_FULL - nneg) : N_CELLS;
    npos = (int'(n_pos_req) > cap) ? cap : int'(n_pos_req);
    for (int i = 0; i < N_CELLS; i++) begin
      rank_lo[i] = 0;
      rank_hi[i] = 0;
      for (int j = 0; j < N_CELLS; j++) begin
        if (j != i && (!neg_half || j < N_FULL)) begin
          if (vcap[j*VW +: VW] < vcap[i*VW +: VW] ||
              (vcap[j*VW +: VW] == vcap[i*VW +: VW] && j < i))
            rank_lo[i] = rank_lo[i] + 1;
          if (vcap[j*VW +: VW] > vcap[i*VW +: VW] ||
              (vcap[j*VW +: VW] == vcap[i*VW +: VW] && j < i))
            rank_hi[i] = rank_hi[i] + 1;
        end
      end
    end
    for (int i = 0; i < N_CELLS; i++) begin
      if (i < N_FULL) begin
        if ((i_pos ? rank_hi[i] : rank_lo[i]) < nneg)      gnext[4*i +: 4] = FB_NEG;
        else if ((i_pos ? rank_lo[i] : rank_hi[i]) < npos) gnext[4*i +: 4] = FB_POS;
        else                                               gnext[4*i +: 4] = alt ? FB_ZB : FB_ZA;
      end else begin
        if (!neg_half && (i_pos ? rank_lo[i] : rank_hi[i]) < npos) gnext[4*i +: 4] = HB_POS;
        else                                                       gnext[4*i +: 4] = HB_BYP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gates   <= '0;
      done    <= 1'b0;
      tripped <= 1'b0;
      alt     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (trip || tripped) begin
        tripped <= 1'b1;
        gates   <= '0;
      end else if (upd) begin
        gates <= gnext;
        done  <= 1'b1;
        alt   <= ~alt;
      end
    end
  end
endmodule

module cell_balance_selector_chk #(
  parameter int N_CELLS = 3,
  parameter int N_FULL  = 2,
  parameter int MAX_NEG = 1,
  parameter int VW      = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 upd,
  input logic                 neg_half,
  input logic                 trip,
  input logic [4*N_CELLS-1:0] gates,
  input logic                 done
);
  int neg_cnt, ins_cnt;
  logic half_byp;
  always_comb begin
    neg_cnt = 0;
    ins_cnt = 0;
    half_byp = 1'b1;
    for (int i = 0; i < N_CELLS; i++) begin
      if (i < N_FULL) begin
        if (gates[4*i +: 4] == 4'b0110) neg_cnt = neg_cnt + 1;
        if (gates[4*i +: 4] == 4'b0110 || gates[4*i +: 4] == 4'b1001) ins_cnt = ins_cnt + 1;
      end else begin
        if (gates[4*i +: 4] != 4'b0100) half_byp = 1'b0;
        if (gates[4*i +: 4] == 4'b1000) ins_cnt = ins_cnt + 1;
      end
    end
  end

  a_r11_trip_opens: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (gates == '0 && !done));
  a_r3_done_follows_upd: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(upd));
  a_r3_hold_without_upd: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !trip) |=> $stable(gates));
  a_r6_half_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(neg_half)) |-> half_byp);
  a_r7_no_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(neg_half)) |-> neg_cnt == 0);
  a_r8_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (neg_cnt <= MAX_NEG && (!$past(neg_half) || ins_cnt <= N_FULL)));
endmodule

bind cell_balance_selector cell_balance_selector_chk #(
  .N_CELLS(N_CELLS), .N_FULL(N_FULL), .MAX_NEG(MAX_NEG), .VW(VW)) u_chk (.*);

// File: tb/cell_balance_selector_tb.sv
module cell_balance_selector_tb;
  localparam int NC = 3, NF = 2, MN = 1, VW = 12, CW = 2;
  logic clk = 0, rst_n = 0, upd = 0, i_pos = 0, neg_half = 0, trip = 0;
  logic [NC*VW-1:0] vcap = '0;
  logic [CW-1:0] n_pos_req = '0, n_neg_req = '0;
  logic [4*NC-1:0] gates;
  logic done;
  int errors = 0, checks = 0;
  logic exp_alt = 0;
  int v [NC];

  always #4 clk = ~clk;

  cell_balance_selector #(.N_CELLS(NC), .N_FULL(NF), .MAX_NEG(MN), .VW(VW)) u_dut (.*);

  function automatic logic [4*NC-1:0] model(input logic ip, input logic nh,
      input int pr, input int nr, input logic a);
    logic [4*NC-1:0] g;
    int lo [NC], hi [NC];
    bit used_lo [NC], used_hi [NC];
    int ne, ps, lim, cnt, b;
    cnt = nh ? NF : NC;
    ne = nh ? ((nr > MN) ? MN : nr) : 0;
    lim = nh ? NF - ne : NC;
    ps = (pr > lim) ? lim : pr;
    for (int k = 0; k < NC; k++) begin used_lo[k] = 0; used_hi[k] = 0; end
    for (int r = 0; r < cnt; r++) begin
      b = -1;
      for (int k = 0; k < cnt; k++) if (!used_lo[k] && (b < 0 || v[k] < v[b])) b = k;
      lo[r] = b; used_lo[b] = 1;
      b = -1;
      for (int k = 0; k < cnt; k++) if (!used_hi[k] && (b < 0 || v[k] > v[b])) b = k;
      hi[r] = b; used_hi[b] = 1;
    end
    for (int k = 0; k < NC; k++) g[4*k +: 4] = (k < NF) ? (a ? 4'b1010 : 4'b0101) : 4'b0100;
    for (int r = 0; r < ps; r++) begin
      b = ip ? lo[r] : hi[r];
      g[4*b +: 4] = (b < NF) ? 4'b1001 : 4'b1000;
    end
    for (int r = 0; r < ne; r++) begin
      b = ip ? hi[r] : lo[r];
      g[4*b +: 4] = 4'b0110;
    end
    return g;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_update(input string req, input logic ip, input logic nh,
      input int pr, input int nr);
    logic [4*NC-1:0] e;
    @(negedge clk);
    for (int k = 0; k < NC; k++) vcap[k*VW +: VW] = v[k][VW-1:0];
    i_pos = ip; neg_half = nh; n_pos_req = pr[CW-1:0]; n_neg_req = nr[CW-1:0]; upd = 1;
    e = model(ip, nh, pr, nr, exp_alt);
    exp_alt = ~exp_alt;
    @(negedge clk);
    upd = 0;
    check({req, " gates"}, 32'(gates), 32'(e));
    check("R3 done", 32'(done), 32'd1);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 gates", 32'(gates), 32'd0);
    check("R1 done", 32'(done), 32'd0);
    rst_n = 1;
    // R10: first update uses 0101 for zero-output full cells
    v = '{10, 20, 30};
    do_update("R10", 1, 1, 0, 0);
    do_update("R10", 1, 1, 0, 0);
    @(negedge clk);
    check("R3 done low", 32'(done), 32'd0);
    // R4 / R5 / R6
    v = '{50, 40, 60};
    do_update("R4", 1, 1, 1, 1);
    do_update("R5", 0, 1, 1, 1);
    do_update("R6", 1, 1, 3, 0);
    // R7 / R8
    do_update("R7", 1, 0, 2, 3);
    do_update("R7", 0, 0, 1, 0);
    do_update("R8", 1, 1, 3, 3);
    do_update("R8", 0, 0, 3, 3);
    // R9: ties
    v = '{7, 7, 7};
    do_update("R9", 1, 1, 1, 1);
    do_update("R9", 0, 0, 2, 0);
    do_update("R9", 1, 0, 1, 0);
    // R2: check encodings directly for a known case
    v = '{100, 5, 9};
    do_update("R2", 1, 1, 1, 1);
    check("R2 neg code", 32'(gates[3:0]), 32'h6);
    check("R2 pos code", 32'(gates[7:4]), 32'h9);
    check("R2 half bypass", 32'(gates[11:8]), 32'h4);
    // random mix
    for (int n = 0; n < 300; n++) begin
      for (int k = 0; k < NC; k++) v[k] = (n % 2) ? int'($urandom % 8) : int'($urandom % 4096);
      do_update(($urandom % 2) ? "R4/R5/R7 rand" : "R8/R9 rand",
                1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 4));
    end
    // R3: hold without strobe
    begin
      logic [4*NC-1:0] held;
      held = gates;
      @(negedge clk);
      v = '{1, 2, 3};
      for (int k = 0; k < NC; k++) vcap[k*VW +: VW] = v[k][VW-1:0];
      repeat (3) @(negedge clk);
      check("R3 hold", 32'(gates), 32'(held));
    end
    // R11
    @(negedge clk); trip = 1;
    @(negedge clk); trip = 0;
    check("R11 open", 32'(gates), 32'd0);
    upd = 1;
    @(negedge clk); upd = 0;
    check("R11 ignore upd", 32'(gates), 32'd0);
    check("R11 no done", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    check("R11 held", 32'(gates), 32'd0);
    rst_n = 0;
    @(negedge clk);
    check("R1 reset gates", 32'(gates), 32'd0);
    rst_n = 1;
    exp_alt = 0;
    v = '{3, 2, 1};
    do_update("R10 restart", 1, 1, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule